// File: doc/BRIEF.md
# No-Turnaround Pipelined Synchronous SRAM

This block is a single-clock synchronous static memory whose address, control and write data all pass through registers. Read data appears two enabled clock edges after its address is taken. Write data is taken the same two enabled edges after its address. Because both directions use the same delay, the data bus can carry a read in one cycle and a write in the next, in any order. The pipeline has no dead cycle at a direction change and accepts one transfer on every enabled clock.

A load cycle takes an external address and starts a read, a write or a deselect. An advance cycle continues the current operation at the next address of a 2-bit burst. The burst follows either a wrapping linear order or an XOR-interleaved order, chosen when the burst is loaded. An active-low clock enable freezes the whole block. Each 9-bit byte lane of a write has its own active-low enable. A read issued directly after a write to the same word returns the bytes that write is storing at that moment.

Top module: `nt_sram`

## Requirements
- R1: While `rst_n` is low, `rd_valid` is 0, `rdata` is 0 and no burst is active.
- R2: A read loaded (`advance`=0, `sel`=1, `wr_n`=1) at enabled edge k sets `rd_valid`=1 and puts the addressed word on `rdata` after enabled edge k+2.
- R3: A write loaded (`advance`=0, `sel`=1, `wr_n`=0) at enabled edge k stores `wdata` as sampled at enabled edge k+2. The write leaves `rd_valid` at 0 in that slot, and later reads return the stored word.
- R4: Byte lane i is `wdata[9i+8:9i]`. It is written only if `lane_wr_n[i]`=0, and `lane_wr_n` is sampled together with the address. A write with all lane enables high leaves the word unchanged.
- R5: An edge with `clk_en_n`=1 is ignored. No register changes, including `rd_valid` and `rdata`, and the two-edge latencies count enabled edges only.
- R6: Reads and writes in any back-to-back mix are accepted one per enabled edge, with no idle cycle at a direction change.
- R7: A read loaded on the edge directly after a write to the same address returns that write's enabled lanes merged over the old word.
- R8: A load with `sel`=0 is a deselect. It gives `rd_valid`=0 two enabled edges later, changes neither the array nor `rdata`, and ends any burst, so later advance cycles also stay idle.
- R9: On an advance cycle (`advance`=1) the beat count n steps 1,2,3,0,... from the load. With linear order the low two address bits are (start+n) mod 4 and the upper bits come from the loaded address.
- R10: If `ilv_order`=1 at the load, the low two address bits of beat n are start XOR n. `ilv_order` is sampled only on load cycles.
- R11: During advance cycles `sel` and `wr_n` are ignored, and the operation type of the load continues. `lane_wr_n` is sampled on every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| advance | input | 1 | 1 = continue burst, 0 = load external address |
| sel | input | 1 | Chip select on load cycles; 0 = deselect |
| wr_n | input | 1 | Active-low write on load cycles |
| lane_wr_n | input | LANES | Active-low per-lane write enables, one per 9-bit lane |
| ilv_order | input | 1 | Burst order at load: 1 = interleaved, 0 = linear |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, taken two enabled edges after its address |
| rdata | output | LANES*LANE_W | Read data, held between reads |
| rd_valid | output | 1 | High for the cycle that carries read data |

## Verification
The bench targets a read placed straight after a write to the same word. A design without the same-edge bypass would return the stale word there. It also inserts stalls between an address and its data slot. A design that let the pipeline or output move on a disabled edge would misalign write data or drop read data. Burst runs start at a non-zero offset in both orders, with the order pin, select and write enable flipped mid-burst. A wrong sequence, a sequence that wraps into the neighbouring block, or one that re-samples control on an advance would land bytes at the wrong address. Deselects followed by advances check that a burst really ends and that `rdata` is left untouched.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   function automatic op_e load_kind(input logic sel, input logic wr);
      if (!sel)    return OP_IDLE;
      else if (wr) return OP_WRITE;
      else         return OP_READ;
   endfunction
endpackage

// File: rtl/nt_sram_burst.sv
module nt_sram_burst
   import nt_sram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int BURST_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic              sel,
   input  logic              wr,
   input  logic              ilv,
   input  logic [ADDR_W-1:0] ext_addr,
   output op_e               issue_op,
   output logic [ADDR_W-1:0] issue_addr
);
   localparam int HI_W = ADDR_W - BURST_BITS;

   op_e                   op_q;
   logic [HI_W-1:0]       base_q;
   logic [BURST_BITS-1:0] start_q;
   logic [BURST_BITS-1:0] cnt_q;
   logic                  ilv_q;
   logic [BURST_BITS-1:0] cnt_nx;
   logic [BURST_BITS-1:0] ofs_nx;

   assign cnt_nx = cnt_q + BURST_BITS'(1);

   always_comb begin
      if (ilv_q) ofs_nx = start_q ^ cnt_nx;
      else       ofs_nx = start_q + cnt_nx;
   end

   always_comb begin
      if (load) begin
         issue_op   = load_kind(sel, wr);
         issue_addr = ext_addr;
      end else begin
         issue_op   = op_q;
         issue_addr = {base_q, ofs_nx};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_IDLE;
         base_q  <= '0;
         start_q <= '0;
         cnt_q   <= '0;
         ilv_q   <= 1'b0;
      end else if (en) begin
         if (load) begin
            op_q    <= load_kind(sel, wr);
            base_q  <= ext_addr[ADDR_W-1:BURST_BITS];
            start_q <= ext_addr[BURST_BITS-1:0];
            cnt_q   <= '0;
            ilv_q   <= ilv;
         end else begin
            cnt_q   <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/nt_sram_array.sv
module nt_sram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    en,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        wr_lane_n,
   input  logic [LANES*LANE_W-1:0] wr_word,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rd_word
);
   localparam int DEPTH = 1 << ADDR_W;

   logic same_word;
   assign same_word = wr_en && (wr_addr == rd_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];
      logic              lane_wr;

      assign lane_wr = wr_en && !wr_lane_n[g];

      always_ff @(posedge clk) begin
         if (en && lane_wr) lane_mem[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
      end

      // same-edge bypass: a lane being written now is returned in its new form
      assign rd_word[g*LANE_W +: LANE_W] = (same_word && !wr_lane_n[g])
                                           ? wr_word[g*LANE_W +: LANE_W]
                                           : lane_mem[rd_addr];
   end
endmodule

// File: rtl/nt_sram.sv
module nt_sram
   import nt_sram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LANES      = 8,
   parameter int LANE_W     = 9,
   parameter int BURST_BITS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    advance,
   input  logic                    sel,
   input  logic                    wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    ilv_order,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rd_valid
);
   localparam int DATA_W = LANES * LANE_W;

   if (BURST_BITS < 1)       begin : g_bad_burst $error("BURST_BITS must be at least 1"); end
   if (ADDR_W <= BURST_BITS) begin : g_bad_addr  $error("ADDR_W must exceed BURST_BITS"); end
   if (LANES < 1)            begin : g_bad_lanes $error("LANES must be at least 1"); end
   if (LANE_W < 1)           begin : g_bad_lw    $error("LANE_W must be at least 1"); end

   logic              en;
   op_e               iss_op;
   logic [ADDR_W-1:0] iss_addr;

   op_e               a_op,     b_op;
   logic [ADDR_W-1:0] a_addr,   b_addr;
   logic [LANES-1:0]  a_lane_n, b_lane_n;
   logic [DATA_W-1:0] arr_word, b_word;

   assign en = !clk_en_n;

   nt_sram_burst #(
      .ADDR_W     (ADDR_W),
      .BURST_BITS (BURST_BITS)
   ) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .load       (!advance),
      .sel        (sel),
      .wr         (!wr_n),
      .ilv        (ilv_order),
      .ext_addr   (addr),
      .issue_op   (iss_op),
      .issue_addr (iss_addr)
   );

   // the write in stage b commits with the data present now; the read in
   // stage a samples the array on the same edge through the bypass
   nt_sram_array #(
      .ADDR_W    (ADDR_W),
      .LANES     (LANES),
      .LANE_W    (LANE_W)
   ) u_array (
      .clk       (clk),
      .en        (en),
      .wr_en     (b_op == OP_WRITE),
      .wr_addr   (b_addr),
      .wr_lane_n (b_lane_n),
      .wr_word   (wdata),
      .rd_addr   (a_addr),
      .rd_word   (arr_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_op     <= OP_IDLE;
         a_addr   <= '0;
         a_lane_n <= '1;
         b_op     <= OP_IDLE;
         b_addr   <= '0;
         b_lane_n <= '1;
         b_word   <= '0;
         rdata    <= '0;
         rd_valid <= 1'b0;
      end else if (en) begin
         a_op     <= iss_op;
         a_addr   <= iss_addr;
         a_lane_n <= lane_wr_n;
         b_op     <= a_op;
         b_addr   <= a_addr;
         b_lane_n <= a_lane_n;
         b_word   <= arr_word;
         rd_valid <= (b_op == OP_READ);
         if (b_op == OP_READ) rdata <= b_word;
      end
   end
endmodule

module nt_sram_chk #(
   parameter int DATA_W = 72
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              advance,
   input logic              sel,
   input logic              wr_n,
   input logic [DATA_W-1:0] rdata,
   input logic              rd_valid
);
   p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !rd_valid);

   p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !advance && sel && wr_n) ##1 !clk_en_n ##1 !clk_en_n |=> rd_valid);

   p_write_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !advance && sel && !wr_n) ##1 !clk_en_n ##1 !clk_en_n |=> !rd_valid);

   p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(rd_valid) && $stable(rdata)));

   p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !advance && !sel) ##1 !clk_en_n ##1 !clk_en_n |=> !rd_valid);

   p_adv_keeps_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !advance && sel && wr_n) ##1 (!clk_en_n && advance)
      ##1 !clk_en_n ##1 !clk_en_n |=> rd_valid);
endmodule

bind nt_sram nt_sram_chk #(.DATA_W(LANES * LANE_W)) u_chk (.*);

// File: tb/tb_nt_sram.sv
`timescale 1ns/1ps
module tb_nt_sram;
   localparam int AW = 6;
   localparam int LN = 8;
   localparam int LW = 9;
   localparam int DW = LN * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          advance = 1'b0;
   logic          sel = 1'b0;
   logic          wr_n = 1'b1;
   logic [LN-1:0] lane_wr_n = '1;
   logic          ilv_order = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rd_valid;

   always #2 clk = ~clk;

   nt_sram dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .advance(advance),
      .sel(sel), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .ilv_order(ilv_order),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   bit    done = 0;

   // behavioural reference: 0 idle, 1 read, 2 write
   typedef struct { int kind; int adr; logic [LN-1:0] ln; } mop_t;
   mop_t          pq[$];
   logic [DW-1:0] mmem [1<<AW];
   logic [DW-1:0] exp_rd = '0;
   bit            exp_v = 0;
   int            b_kind = 0, b_base = 0, b_start = 0, b_cnt = 0;
   bit            b_ilv = 0;

   always @(posedge clk) begin
      mop_t nw, od;
      if (!rst_n) begin
         pq.delete();
         pq.push_back('{kind:0, adr:0, ln:'1});
         pq.push_back('{kind:0, adr:0, ln:'1});
         b_kind = 0; b_cnt = 0; exp_v = 0; exp_rd = '0;
      end else if (!clk_en_n) begin
         if (!advance) begin
            b_kind  = sel ? (wr_n ? 1 : 2) : 0;
            b_base  = int'(addr);
            b_start = int'(addr) % 4;
            b_cnt   = 0;
            b_ilv   = ilv_order;
            nw.adr  = int'(addr);
         end else begin
            b_cnt  = (b_cnt + 1) % 4;
            nw.adr = (b_base / 4) * 4 + (b_ilv ? (b_start ^ b_cnt) : (b_start + b_cnt) % 4);
         end
         nw.kind = b_kind;
         nw.ln   = lane_wr_n;
         od = pq.pop_front();
         if (od.kind == 2)
            for (int i = 0; i < LN; i++)
               if (!od.ln[i]) mmem[od.adr][i*LW +: LW] = wdata[i*LW +: LW];
         if (od.kind == 1) begin exp_rd = mmem[od.adr]; exp_v = 1; end
         else exp_v = 0;
         pq.push_back(nw);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (rd_valid !== exp_v) begin
            errors++;
            $display("FAIL %s: rd_valid got %0b expected %0b at %0t", tag, rd_valid, exp_v, $time);
         end
         checks++;
         if (rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s: rdata got %h expected %h at %0t", tag, rdata, exp_rd, $time);
         end
      end
   end

   function automatic logic [DW-1:0] rnd_word();
      logic [95:0] t;
      t = {$urandom(), $urandom(), $urandom()};
      return t[DW-1:0];
   endfunction

   task automatic cyc(input bit adv, input bit s, input bit w, input int a,
                      input logic [LN-1:0] ln, input bit ilv);
      @(negedge clk);
      clk_en_n  = 1'b0;
      advance   = adv;
      sel       = s;
      wr_n      = !w;
      addr      = a[AW-1:0];
      lane_wr_n = ln;
      ilv_order = ilv;
      wdata     = rnd_word();
   endtask

   task automatic stall(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         clk_en_n  = 1'b1;
         advance   = 1'($urandom_range(0, 1));
         sel       = 1'($urandom_range(0, 1));
         wr_n      = 1'($urandom_range(0, 1));
         addr      = AW'($urandom_range(0, (1 << AW) - 1));
         lane_wr_n = LN'($urandom());
         ilv_order = 1'($urandom_range(0, 1));
         wdata     = rnd_word();
      end
   endtask

   task automatic rd(input int a);            cyc(0, 1, 0, a, '1, 0); endtask
   task automatic wr(input int a, input logic [LN-1:0] ln); cyc(0, 1, 1, a, ln, 0); endtask
   task automatic desel(input int n); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '1, 0); endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      checks++;
      if (rd_valid !== 1'b0 || rdata !== '0) begin
         errors++;
         $display("FAIL R1: rd_valid=%0b rdata=%h expected 0 and 0", rd_valid, rdata);
      end
      rst_n = 1'b1;

      tag = "R3";   // fill every word through full-lane writes
      for (int a = 0; a < (1 << AW); a++) wr(a, '0);
      desel(2);

      tag = "R2";
      for (int a = 0; a < 8; a++) rd(a);
      desel(3);

      tag = "R4";   // partial lanes, then no lanes
      wr(5, 8'b1010_0101); desel(1); rd(5);
      wr(6, 8'hff); desel(1); rd(6);
      desel(3);

      tag = "R6";   // alternating directions, no gaps
      for (int i = 0; i < 10; i++) begin wr(16 + i, '0); rd(16 + i - 1); end
      desel(3);

      tag = "R7";   // read directly behind a write to the same word
      wr(9, 8'h0f); rd(9);
      wr(10, 8'hf0); rd(10); wr(10, 8'h3c); rd(10);
      desel(3);

      tag = "R5";   // stalls inside the read and write pipelines
      rd(3); rd(4); stall(5); rd(5);
      wr(3, 8'h55); stall(3); rd(3); stall(2);
      desel(3);

      tag = "R8";   // deselect, then advances that must stay idle
      rd(1); desel(1); rd(2); desel(1);
      cyc(1, 1, 0, 0, '1, 0); cyc(1, 1, 1, 0, '0, 0); rd(1);
      desel(3);

      tag = "R9";   // linear bursts from a non-zero start
      cyc(0, 1, 1, 14, '0, 0);
      for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, '0, 0);
      for (int a = 12; a < 16; a++) rd(a);
      cyc(0, 1, 0, 13, '1, 0);
      for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, '1, 0);
      desel(3);

      tag = "R10";  // interleaved bursts; order pin flipped mid-burst
      cyc(0, 1, 1, 22, '0, 1);
      for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0, '0, 0);
      for (int a = 20; a < 24; a++) rd(a);
      cyc(0, 1, 0, 21, '1, 1);
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, '1, 0);
      desel(3);

      tag = "R11";  // select and write enable ignored while advancing
      cyc(0, 1, 0, 30, '1, 0);
      cyc(1, 0, 1, 0, '0, 0); cyc(1, 1, 1, 0, '0, 0); cyc(1, 0, 0, 0, '0, 1);
      cyc(0, 1, 1, 40, 8'h0f, 0);
      cyc(1, 0, 0, 0, 8'hf0, 0); cyc(1, 1, 0, 0, 8'h00, 0); cyc(1, 0, 1, 0, 8'h33, 0);
      for (int a = 40; a < 44; a++) rd(a);
      desel(3);

      tag = "R6";   // mixed traffic with bursts and stalls
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 7) == 0) stall(1);
         else cyc(($urandom_range(0, 2) == 0), ($urandom_range(0, 7) != 0),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, (1 << AW) - 1)),
                  LN'($urandom()), 1'($urandom_range(0, 1)));
      end
      desel(4);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule